// File: doc/BRIEF.md
# Masked Pseudo-Random Pattern Source

This block is an on-chip test pattern source. After a start pulse it emits one test vector per clock cycle. The first stretch of vectors is plain pseudo-random data from a Galois LFSR. After that, the block works through a fixed table of partial vectors. In each table entry an enable word marks which bit positions are pinned. For each of those positions the entry's value bit is sent instead of the random bit. All other positions still carry the LFSR bit.

The table, the warm-up length, the LFSR taps and the seed are elaboration parameters. Each entry has its own raw repeat count, which is forced into the range 2 to 200. The block orders the entries by how many bits they pin, so loosely constrained entries run before tightly constrained ones. The table does not have to be written in that order. A consumer latches the vector whenever the valid strobe is high. It can use the mask index to tag which entry shaped the vector, and it can use the done pulse to close the session.

Top module: `maskgen_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, vec_valid, mask_on and done are all 0.
- R2: A start pulse seen in an idle cycle loads the LFSR with SEED. In the next cycle vec_valid is 1 and vec_out equals SEED.
- R3: The LFSR shifts right in Galois form (next = s>>1, XOR TAPS when s[0] was 1). It advances exactly once per emitted vector and never reaches zero.
- R4: The first WARMUP vectors of a session have mask_on = 0, and vec_out equals the raw LFSR state.
- R5: During a mask phase, each bit b of vec_out is value[b] where enable[b] is 1, and the LFSR bit where enable[b] is 0. Entry i sits at bits [i*WIDTH +: WIDTH] of MASK_VAL and MASK_EN.
- R6: Entry i runs for a number of consecutive vectors given by its raw 8-bit count at MASK_CNT[i*8 +: 8]. Raw counts below 2 run as 2, and counts above 200 run as 200.
- R7: Entries run in ascending order of enable popcount. Ties go to the lower table index. While mask_on is 1, mask_idx gives the table index of the entry in use.
- R8: In the cycle after the last vector of the last entry, done is 1 for one cycle and vec_valid is 0. The block then stays idle until the next start.
- R9: A start pulse while a session is running is ignored, and the vector stream carries on unchanged.
- R10: Reset in the middle of a session ends it at once. No vectors follow until a new start arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Session start pulse, taken only when idle |
| vec_valid | output | 1 | A test vector is on vec_out this cycle |
| vec_out | output | WIDTH | Merged test vector |
| mask_on | output | 1 | Current vector is shaped by a table entry |
| mask_idx | output | IDX_W | Table index of the entry in use (0 when mask_on is 0) |
| done | output | 1 | One-cycle pulse after the final vector |

## Verification
The bench uses WIDTH 16, four table entries, a warm-up of 20 vectors, taps 0xB400 and seed 0xACE1. A full session is therefore 229 vectors and is checked vector by vector against a reference LFSR. The table is written out of popcount order and includes two entries with equal popcount, so the sort and its tie rule are exercised. The raw counts 0, 1 and 250 hit both clamp bounds. The 200-vector entry runs through the counter's widest value.

// File: rtl/maskgen_pkg.sv
package maskgen_pkg;

    localparam int CNT_RAW_W = 8;
    localparam int CNT_MIN   = 2;
    localparam int CNT_MAX   = 200;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WARM = 2'd1,
        PH_MASK = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   done;
    } seq_ctl_t;

    function automatic int clamp_count(input int raw);
        if (raw < CNT_MIN) return CNT_MIN;
        if (raw > CNT_MAX) return CNT_MAX;
        return raw;
    endfunction

    function automatic int popcount64(input logic [63:0] v);
        int n;
        n = 0;
        for (int b = 0; b < 64; b++) begin
            if (v[b]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/maskgen_lfsr.sv
module maskgen_lfsr #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS  = 16'hB400,
    parameter logic [WIDTH-1:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    output logic [WIDTH-1:0] state
);
    logic [WIDTH-1:0] nxt;

    always_comb begin
        nxt = state >> 1;
        if (state[0]) nxt = nxt ^ TAPS;
    end

    always_ff @(posedge clk) begin
        if (rst)       state <= SEED;
        else if (load) state <= SEED;
        else if (step) state <= nxt;
    end

    // R3
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    // R3
    lfsr_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> state != $past(state));

    // R3
    lfsr_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(state));

endmodule

// File: rtl/maskgen_table.sv
module maskgen_table #(
    parameter int                             WIDTH     = 16,
    parameter int                             NUM_MASKS = 4,
    parameter logic [NUM_MASKS*WIDTH-1:0]     MASK_VAL  = '0,
    parameter logic [NUM_MASKS*WIDTH-1:0]     MASK_EN   = '0,
    parameter logic [NUM_MASKS*8-1:0]         MASK_CNT  = '0,
    localparam int                            IDX_W     = (NUM_MASKS > 1) ? $clog2(NUM_MASKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] slot_i,
    output logic [WIDTH-1:0] val_o,
    output logic [WIDTH-1:0] en_o,
    output logic [7:0]       cnt_o,
    output logic [IDX_W-1:0] src_o
);
    import maskgen_pkg::*;

    function automatic int entry_pop(input int i);
        return popcount64(64'(MASK_EN[i*WIDTH +: WIDTH]));
    endfunction

    // Table index that lands in run position k.
    function automatic int slot_source(input int k);
        int rank;
        for (int i = 0; i < NUM_MASKS; i++) begin
            rank = 0;
            for (int j = 0; j < NUM_MASKS; j++) begin
                if (entry_pop(j) < entry_pop(i) ||
                    (entry_pop(j) == entry_pop(i) && j < i))
                    rank++;
            end
            if (rank == k) return i;
        end
        return 0;
    endfunction

    logic [WIDTH-1:0] val_tab [NUM_MASKS];
    logic [WIDTH-1:0] en_tab  [NUM_MASKS];
    logic [7:0]       cnt_tab [NUM_MASKS];
    logic [IDX_W-1:0] src_tab [NUM_MASKS];

    for (genvar k = 0; k < NUM_MASKS; k++) begin : g_slot
        localparam int         SRC = slot_source(k);
        localparam logic [7:0] CNT = 8'(clamp_count(int'(MASK_CNT[SRC*8 +: 8])));
        assign val_tab[k] = MASK_VAL[SRC*WIDTH +: WIDTH];
        assign en_tab[k]  = MASK_EN[SRC*WIDTH +: WIDTH];
        assign cnt_tab[k] = CNT;
        assign src_tab[k] = IDX_W'(SRC);
    end

    assign val_o = val_tab[slot_i];
    assign en_o  = en_tab[slot_i];
    assign cnt_o = cnt_tab[slot_i];
    assign src_o = src_tab[slot_i];

    // R7
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(slot_i) < NUM_MASKS);

endmodule

// File: rtl/maskgen_seq.sv
module maskgen_seq #(
    parameter int  NUM_MASKS = 4,
    parameter int  WARMUP    = 2000,
    localparam int IDX_W     = (NUM_MASKS > 1) ? $clog2(NUM_MASKS) : 1,
    localparam int SPAN      = (WARMUP > maskgen_pkg::CNT_MAX) ? WARMUP : maskgen_pkg::CNT_MAX,
    localparam int CW        = $clog2(SPAN + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [7:0]          slot_cnt_i,
    output maskgen_pkg::phase_e phase_o,
    output logic [IDX_W-1:0]    slot_o,
    output logic                done_o
);
    import maskgen_pkg::*;

    seq_ctl_t         ctl_q;
    logic [CW-1:0]    cnt_q;
    logic [IDX_W-1:0] slot_q;
    logic             last_vec;
    logic             last_slot;
    logic             busy;

    assign busy      = ctl_q.phase != PH_IDLE;
    assign last_slot = slot_q == IDX_W'(NUM_MASKS - 1);

    always_comb begin
        last_vec = 1'b0;
        if (ctl_q.phase == PH_WARM)
            last_vec = cnt_q == CW'(WARMUP - 1);
        else if (ctl_q.phase == PH_MASK)
            last_vec = cnt_q == CW'(slot_cnt_i - 8'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{phase: PH_IDLE, done: 1'b0};
            cnt_q  <= '0;
            slot_q <= '0;
        end else begin
            ctl_q.done <= 1'b0;
            unique case (ctl_q.phase)
                PH_IDLE: begin
                    if (start_i) begin
                        ctl_q.phase <= PH_WARM;
                        cnt_q       <= '0;
                        slot_q      <= '0;
                    end
                end
                PH_WARM: begin
                    if (last_vec) begin
                        ctl_q.phase <= PH_MASK;
                        cnt_q       <= '0;
                        slot_q      <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_MASK: begin
                    if (last_vec) begin
                        cnt_q <= '0;
                        if (last_slot) begin
                            ctl_q.phase <= PH_IDLE;
                            ctl_q.done  <= 1'b1;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ctl_q.phase <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = ctl_q.phase;
    assign slot_o  = slot_q;
    assign done_o  = ctl_q.done;

    // R2
    begin_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_i));

    // R6
    mask_run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.phase == PH_MASK) |-> 32'(cnt_q) < CNT_MAX);

    // R7
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.phase == PH_MASK && $past(ctl_q.phase) == PH_MASK && slot_q != $past(slot_q))
            |-> slot_q == $past(slot_q) + 1'b1);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.done |-> !busy);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.done |=> !ctl_q.done);

    // R9
    restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.phase == PH_WARM && start_i && !last_vec) |=> ctl_q.phase == PH_WARM);

endmodule

// File: rtl/maskgen_merge.sv
module maskgen_merge #(
    parameter int WIDTH = 16
) (
    input  logic             apply_i,
    input  logic [WIDTH-1:0] rnd_i,
    input  logic [WIDTH-1:0] val_i,
    input  logic [WIDTH-1:0] en_i,
    output logic [WIDTH-1:0] vec_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign vec_o[b] = (apply_i && en_i[b]) ? val_i[b] : rnd_i[b];
    end
endmodule

// File: rtl/maskgen_top.sv
module maskgen_top #(
    parameter int                         WIDTH     = 16,
    parameter int                         NUM_MASKS = 4,
    parameter int                         WARMUP    = 2000,
    parameter logic [WIDTH-1:0]           TAPS      = 16'hB400,
    parameter logic [WIDTH-1:0]           SEED      = 16'hACE1,
    parameter logic [NUM_MASKS*WIDTH-1:0] MASK_VAL  = 64'h0015_8000_0001_5A00,
    parameter logic [NUM_MASKS*WIDTH-1:0] MASK_EN   = 64'h001F_8100_0003_FF00,
    parameter logic [NUM_MASKS*8-1:0]     MASK_CNT  = 32'h64_64_64_64,
    localparam int                        IDX_W     = (NUM_MASKS > 1) ? $clog2(NUM_MASKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             vec_valid,
    output logic [WIDTH-1:0] vec_out,
    output logic             mask_on,
    output logic [IDX_W-1:0] mask_idx,
    output logic             done
);
    import maskgen_pkg::*;

    phase_e           phase;
    logic [IDX_W-1:0] slot;
    logic [WIDTH-1:0] rnd;
    logic [WIDTH-1:0] cur_val;
    logic [WIDTH-1:0] cur_en;
    logic [7:0]       cur_cnt;
    logic [IDX_W-1:0] cur_src;
    logic             busy;
    logic             load;

    assign busy = phase != PH_IDLE;
    assign load = start && phase == PH_IDLE;

    maskgen_lfsr #(.WIDTH(WIDTH), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
        .clk(clk), .rst(rst), .load(load), .step(busy), .state(rnd)
    );

    maskgen_table #(
        .WIDTH(WIDTH), .NUM_MASKS(NUM_MASKS),
        .MASK_VAL(MASK_VAL), .MASK_EN(MASK_EN), .MASK_CNT(MASK_CNT)
    ) u_table (
        .clk(clk), .rst(rst), .slot_i(slot),
        .val_o(cur_val), .en_o(cur_en), .cnt_o(cur_cnt), .src_o(cur_src)
    );

    maskgen_seq #(.NUM_MASKS(NUM_MASKS), .WARMUP(WARMUP)) u_seq (
        .clk(clk), .rst(rst), .start_i(start), .slot_cnt_i(cur_cnt),
        .phase_o(phase), .slot_o(slot), .done_o(done)
    );

    maskgen_merge #(.WIDTH(WIDTH)) u_merge (
        .apply_i(phase == PH_MASK), .rnd_i(rnd),
        .val_i(cur_val), .en_i(cur_en), .vec_o(vec_out)
    );

    assign vec_valid = busy;
    assign mask_on   = phase == PH_MASK;
    assign mask_idx  = mask_on ? cur_src : '0;

    // R5
    pinned_bits_chk: assert property (@(posedge clk) disable iff (rst)
        mask_on |-> ((vec_out ^ cur_val) & cur_en) == '0);

    // R5
    free_bits_chk: assert property (@(posedge clk) disable iff (rst)
        mask_on |-> ((vec_out ^ rnd) & ~cur_en) == '0);

    // R4
    warm_raw_chk: assert property (@(posedge clk) disable iff (rst)
        !mask_on |-> vec_out == rnd);

endmodule

// File: tb/maskgen_top_tb_top.sv
module maskgen_top_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          W          = 16;
    localparam int          NM         = 4;
    localparam int          WARM       = 20;
    localparam logic [15:0] TAPS_B     = 16'hB400;
    localparam logic [15:0] SEED_B     = 16'hACE1;

    // Table entries in index order: enable, value, raw count.
    localparam logic [15:0] T_EN  [NM] = '{16'hFF00, 16'h0003, 16'h001F, 16'h8100};
    localparam logic [15:0] T_VAL [NM] = '{16'h5A00, 16'h0001, 16'h0015, 16'h8000};
    localparam logic [7:0]  T_CNT [NM] = '{8'd5, 8'd1, 8'd250, 8'd0};
    // Expected run order (popcounts 8,2,5,2 -> 1,3,2,0) and clamped lengths.
    localparam int          EXP_ORD [NM] = '{1, 3, 2, 0};
    localparam int          EXP_LEN [NM] = '{2, 2, 200, 5};

    localparam logic [NM*W-1:0] P_VAL = {T_VAL[3], T_VAL[2], T_VAL[1], T_VAL[0]};
    localparam logic [NM*W-1:0] P_EN  = {T_EN[3], T_EN[2], T_EN[1], T_EN[0]};
    localparam logic [NM*8-1:0] P_CNT = {T_CNT[3], T_CNT[2], T_CNT[1], T_CNT[0]};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        vec_valid;
    logic [15:0] vec_out;
    logic        mask_on;
    logic [1:0]  mask_idx;
    logic        done;

    int checks = 0;
    int errs   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    maskgen_top #(
        .WIDTH(W), .NUM_MASKS(NM), .WARMUP(WARM), .TAPS(TAPS_B), .SEED(SEED_B),
        .MASK_VAL(P_VAL), .MASK_EN(P_EN), .MASK_CNT(P_CNT)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .vec_valid(vec_valid),
        .vec_out(vec_out), .mask_on(mask_on), .mask_idx(mask_idx), .done(done)
    );

    function automatic logic [15:0] ref_next(input logic [15:0] s);
        return s[0] ? ((s >> 1) ^ TAPS_B) : (s >> 1);
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Walks one full session; on entry the first vector is on the ports.
    task automatic walk_session(input int poke_at);
        logic [15:0] s = SEED_B;
        int          n = 0;
        for (int k = -1; k < NM; k++) begin
            int len = (k < 0) ? WARM : EXP_LEN[k];
            for (int v = 0; v < len; v++) begin
                logic [15:0] exp_v = s;
                if (k >= 0) exp_v = (s & ~T_EN[EXP_ORD[k]]) | (T_VAL[EXP_ORD[k]] & T_EN[EXP_ORD[k]]);
                check(vec_valid === 1'b1, "R2/R6 vec_valid during session", 64'(vec_valid), 64'd1);
                check(vec_out === exp_v, (k < 0) ? "R4 warm-up vector" : "R5 masked vector",
                      64'(vec_out), 64'(exp_v));
                check(mask_on === (k >= 0), "R4 mask_on", 64'(mask_on), 64'(k >= 0));
                if (k >= 0)
                    check(mask_idx === 2'(EXP_ORD[k]), "R7 mask order", 64'(mask_idx), 64'(EXP_ORD[k]));
                check(done === 1'b0, "R8 no early done", 64'(done), 64'd0);
                s = ref_next(s);   // R3 reference step
                n++;
                start = (n == poke_at);  // R9 stray start mid-session
                @(negedge clk);
            end
        end
        start = 1'b0;
        check(done === 1'b1, "R8 done after last vector", 64'(done), 64'd1);
        check(vec_valid === 1'b0, "R8 valid low with done", 64'(vec_valid), 64'd0);
        @(negedge clk);
        check(done === 1'b0, "R8 done single cycle", 64'(done), 64'd0);
        for (int i = 0; i < 5; i++) begin
            check(vec_valid === 1'b0, "R8 stays idle", 64'(vec_valid), 64'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errs++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(vec_valid === 1'b0, "R1 valid in reset", 64'(vec_valid), 64'd0);
        check(done === 1'b0, "R1 done in reset", 64'(done), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(vec_valid === 1'b0 && mask_on === 1'b0, "R1 idle after reset",
              64'({vec_valid, mask_on}), 64'd0);

        // Session 1: plain walk
        pulse_start();
        check(vec_out === SEED_B, "R2 first vector is seed", 64'(vec_out), 64'(SEED_B));
        walk_session(-1);

        // Session 2: stray start mid-session must not disturb the stream (R9)
        pulse_start();
        walk_session(7);

        // R10 reset mid-session
        pulse_start();
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            check(vec_valid === 1'b0 && done === 1'b0, "R10 idle after abort",
                  64'({vec_valid, done}), 64'd0);
            @(negedge clk);
        end
        pulse_start();
        check(vec_out === SEED_B, "R10 restart from seed", 64'(vec_out), 64'(SEED_B));
        walk_session(-1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule